// File: doc/BRIEF.md
# Watchdog Timer with Grace Delay Before Reset

The block watches for a stalled program. A 20-bit up counter runs on the watchdog clock from the last restart. When it reaches a selected power-of-four boundary, a sticky timeout flag is raised and an interrupt is requested. If resets are enabled, a grace counter is then loaded. Software can still restart the watchdog while that counter runs. If the grace counter runs out first, the block emits a one-cycle reset request.

Software reaches the block through a small register set of two words. Word 0 carries the restart and flag-clear commands together with the configuration fields. Word 1 holds the protection bit. The configuration fields only change while that protection bit is open. After reset the watchdog is running, with resets and interrupts enabled and the longest period selected.

The controller has four states. OFF: disabled. RUN: counting toward the timeout. GRACE: counting down the reset delay. FIRE: the reset request is asserted. Its transitions are:
- OFF→RUN when enabled.
- RUN→OFF, GRACE→OFF and FIRE→OFF when disabled.
- RUN→GRACE on a timeout with resets enabled.
- GRACE→RUN on a restart command.
- GRACE→FIRE when the delay expires.
- FIRE→RUN after the single pulse.

Top module: `wdog_timer`

Register word 0 (`reg_sel`=0), write fields:
- bit 0: restart (kick)
- bit 1: flag clear (write 1)
- bit 2: enable
- bit 3: reset enable
- bit 4: interrupt enable
- bits 8:5: period select
- bits 10:9: delay select

Reading word 0 returns the same layout, with bit 1 holding the timeout flag and bit 0 reading 0. Register word 1: bit 0 is the protection bit, where 1 means open. Every other read bit is 0.

## Requirements
- R1: After a restart (write word 0 with bit 0 set), the first timeout occurs exactly 2^(4+2·P) watchdog clocks later, where P is the period select. The timeout raises `tmo_flag` in that cycle, and the counter starts again from zero.
- R2: The period select has nine legal values, 0..8. A written value above 8 is stored and read back as 8.
- R3: `tmo_flag` stays at 1 once set and is cleared only by writing 1 to bit 1 of word 0. If a timeout and a clear fall in the same cycle, the timeout wins.
- R4: `irq` equals `tmo_flag` AND the interrupt-enable bit.
- R5: With reset enable set, `rst_req` is asserted D clocks after the cycle in which `tmo_flag` rose. D is 3, 18, 130 or 1026 for delay select 0, 1, 2 or 3.
- R6: `rst_req` is high for exactly one clock per expired delay. Afterwards the counter restarts from zero.
- R7: A restart command during the grace delay cancels the pending reset request and restarts the counter. The restart command works whether the protection bit is open or closed.
- R8: After reset, word 0 reads 0x71C. This means enabled, reset enable 1, interrupt enable 1, period 8 and delay select 3. The flag is 0 and `rst_req` is 0.
- R9: A write to the configuration fields is ignored while the protection bit is 0. The protection bit is 0 after reset.
- R10: When disabled, the block raises no timeout and no reset request.
- R11: With reset enable 0, a timeout sets the flag but never asserts `rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register word select (0 control, 1 protection) |
| wdata | input | 11 | Write data |
| rdata | output | 11 | Read data of the selected word |
| irq | output | 1 | Timeout interrupt request |
| tmo_flag | output | 1 | Sticky timeout flag |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The case that is hardest to reach is a restart that arrives late in the grace delay. It must cancel the reset request without disturbing the flag, and the next timeout must start from a fresh counter. The bench first opens the protection bit and programs a short period with the longest delay. It waits for the flag, lets the delay run partway, then issues the restart. It then watches the reset output for a window longer than the remaining delay. A behavioural model of the counter, delay and flag is compared with every output on each clock. Through that model, same-cycle races between a timeout and a restart or clear are also covered.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_GRACE = 2'd2,
        ST_FIRE  = 2'd3
    } wd_state_e;

    localparam int unsigned DATA_W   = 11;
    localparam int unsigned PSEL_W   = 4;
    localparam int unsigned DSEL_W   = 2;

    localparam int unsigned B_KICK   = 0;
    localparam int unsigned B_FCLR   = 1;
    localparam int unsigned B_EN     = 2;
    localparam int unsigned B_RSTEN  = 3;
    localparam int unsigned B_IRQEN  = 4;
    localparam int unsigned B_PSEL   = 5;
    localparam int unsigned B_DSEL   = 9;

    typedef struct packed {
        logic              en;
        logic              rst_en;
        logic              irq_en;
        logic [PSEL_W-1:0] psel;
        logic [DSEL_W-1:0] dsel;
    } wd_cfg_t;

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned PSEL_MAX  = 8,
    parameter int unsigned PSEL_RST  = 8,
    parameter int unsigned DSEL_RST  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output wd_cfg_t           cfg,
    output logic              kick,
    output logic              flag,
    output logic [DATA_W-1:0] rdata
);

    wd_cfg_t           cfg_q;
    logic              unlock_q;
    logic              flag_q;
    logic              ctl_wr;
    logic              fclr;
    logic [PSEL_W-1:0] psel_in;

    always_comb begin
        ctl_wr  = wr_en && !reg_sel;
        kick    = ctl_wr && wdata[B_KICK];
        fclr    = ctl_wr && wdata[B_FCLR];
        psel_in = wdata[B_PSEL +: PSEL_W];
        if (psel_in > PSEL_W'(PSEL_MAX))
            psel_in = PSEL_W'(PSEL_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.en     <= 1'b1;
            cfg_q.rst_en <= 1'b1;
            cfg_q.irq_en <= 1'b1;
            cfg_q.psel   <= PSEL_W'(PSEL_RST);
            cfg_q.dsel   <= DSEL_W'(DSEL_RST);
            unlock_q     <= 1'b0;
            flag_q       <= 1'b0;
        end else begin
            if (ctl_wr && unlock_q) begin
                cfg_q.en     <= wdata[B_EN];
                cfg_q.rst_en <= wdata[B_RSTEN];
                cfg_q.irq_en <= wdata[B_IRQEN];
                cfg_q.psel   <= psel_in;
                cfg_q.dsel   <= wdata[B_DSEL +: DSEL_W];
            end
            if (wr_en && reg_sel)
                unlock_q <= wdata[0];
            if (tick)
                flag_q <= 1'b1;
            else if (fclr)
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (reg_sel) begin
            rdata[0] = unlock_q;
        end else begin
            rdata[B_FCLR]               = flag_q;
            rdata[B_EN]                 = cfg_q.en;
            rdata[B_RSTEN]              = cfg_q.rst_en;
            rdata[B_IRQEN]              = cfg_q.irq_en;
            rdata[B_PSEL +: PSEL_W]     = cfg_q.psel;
            rdata[B_DSEL +: DSEL_W]     = cfg_q.dsel;
        end
    end

    assign cfg  = cfg_q;
    assign flag = flag_q;

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock_q |=> $stable(cfg_q)); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !fclr) |=> flag_q); // R3
    AST_PSEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && unlock_q |=> cfg_q.psel <= PSEL_W'(PSEL_MAX)); // R2

endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W    = 20,
    parameter int unsigned TAP_BASE = 4,
    parameter int unsigned TAP_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clr,
    input  logic [PSEL_W-1:0] sel,
    output logic              tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   lim;
    logic             at_tap;

    always_comb begin
        lim    = {{CNT_W{1'b0}}, 1'b1} << (TAP_BASE + TAP_STEP * int'(sel));
        at_tap = ({1'b0, cnt_q} == (lim - 1'b1));
        tick   = run && !clr && at_tap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || tick)
            cnt_q <= '0;
        else if (run)
            cnt_q <= cnt_q + 1'b1;
    end

    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt_q == '0); // R1
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0); // R7

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int unsigned DLY_A = 3,
    parameter int unsigned DLY_B = 18,
    parameter int unsigned DLY_C = 130,
    parameter int unsigned DLY_D = 1026
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rst_en,
    input  logic [DSEL_W-1:0] dsel,
    input  logic              kick,
    input  logic              tick,
    output logic              run,
    output logic              rst_pulse
);

    localparam int unsigned DLY_W = $clog2(DLY_D);

    wd_state_e        st_q, st_d;
    logic [DLY_W-1:0] dly_q;
    logic             dly_load;

    function automatic logic [DLY_W-1:0] dly_init(input logic [DSEL_W-1:0] s);
        unique case (s)
            2'd0:    return DLY_W'(DLY_A - 1);
            2'd1:    return DLY_W'(DLY_B - 1);
            2'd2:    return DLY_W'(DLY_C - 1);
            default: return DLY_W'(DLY_D - 1);
        endcase
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_RUN;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF:   if (en) st_d = ST_RUN;
            ST_RUN: begin
                if (!en)                 st_d = ST_OFF;
                else if (tick && rst_en) st_d = ST_GRACE;
            end
            ST_GRACE: begin
                if (!en)                 st_d = ST_OFF;
                else if (kick)           st_d = ST_RUN;
                else if (dly_q == '0)    st_d = ST_FIRE;
            end
            ST_FIRE:  st_d = en ? ST_RUN : ST_OFF;
            default:  st_d = ST_OFF;
        endcase
    end

    always_comb begin
        run       = (st_q == ST_RUN);
        rst_pulse = (st_q == ST_FIRE);
        dly_load  = (st_q == ST_RUN) && tick && rst_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dly_q <= '0;
        else if (dly_load)
            dly_q <= dly_init(dsel);
        else if (st_q == ST_GRACE && dly_q != '0)
            dly_q <= dly_q - 1'b1;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse |=> !rst_pulse); // R6
    AST_KICK_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GRACE && kick) |=> !rst_pulse); // R7
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF && !en) |=> !rst_pulse); // R10
    AST_GRACE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && st_d == ST_GRACE) |-> (tick && rst_en)); // R11

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W    = 20,
    parameter int unsigned TAP_BASE = 4,
    parameter int unsigned TAP_STEP = 2,
    parameter int unsigned N_SEL    = 9,
    parameter int unsigned DLY_A    = 3,
    parameter int unsigned DLY_B    = 18,
    parameter int unsigned DLY_C    = 130,
    parameter int unsigned DLY_D    = 1026
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              tmo_flag,
    output logic              rst_req
);

    localparam int unsigned PSEL_MAX = N_SEL - 1;

    wd_cfg_t cfg;
    logic    kick;
    logic    tick;
    logic    run;
    logic    flag;

    wdog_regs #(
        .PSEL_MAX (PSEL_MAX),
        .PSEL_RST (PSEL_MAX),
        .DSEL_RST (3)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .reg_sel (reg_sel),
        .wdata   (wdata),
        .tick    (tick),
        .cfg     (cfg),
        .kick    (kick),
        .flag    (flag),
        .rdata   (rdata)
    );

    wdog_count #(
        .CNT_W    (CNT_W),
        .TAP_BASE (TAP_BASE),
        .TAP_STEP (TAP_STEP)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (kick || !run),
        .sel   (cfg.psel),
        .tick  (tick)
    );

    wdog_fsm #(
        .DLY_A (DLY_A),
        .DLY_B (DLY_B),
        .DLY_C (DLY_C),
        .DLY_D (DLY_D)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg.en),
        .rst_en    (cfg.rst_en),
        .dsel      (cfg.dsel),
        .kick      (kick),
        .tick      (tick),
        .run       (run),
        .rst_pulse (rst_req)
    );

    assign tmo_flag = flag;
    assign irq      = flag && cfg.irq_en;

    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> tmo_flag); // R4
    AST_PULSE_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(tmo_flag) || $past(tick)); // R5

endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [10:0] wdata = '0;
    logic [10:0] rdata;
    logic        irq, tmo_flag, rst_req;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    wdog_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .irq(irq), .tmo_flag(tmo_flag),
        .rst_req(rst_req)
    );

    always #5 clk = ~clk;

    // behavioural reference model
    int m_st, m_cnt, m_dly;
    bit m_flag, m_en, m_ren, m_ien, m_unl;
    int m_psel, m_dsel;

    function automatic int dly_of(int s);
        case (s)
            0: return 3;
            1: return 18;
            2: return 130;
            default: return 1026;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 1; m_cnt = 0; m_dly = 0; m_flag = 0;
            m_en = 1; m_ren = 1; m_ien = 1; m_unl = 0;
            m_psel = 8; m_dsel = 3;
        end else begin
            int  lim;
            bit  k, fc, runs, tk;
            int  nst;
            lim  = 1 << (4 + 2 * m_psel);
            k    = wr_en && !reg_sel && wdata[0];
            fc   = wr_en && !reg_sel && wdata[1];
            runs = (m_st == 1);
            tk   = runs && !k && (m_cnt == lim - 1);
            nst  = m_st;
            case (m_st)
                0: if (m_en) nst = 1;
                1: if (!m_en) nst = 0;
                   else if (tk && m_ren) begin nst = 2; m_dly = dly_of(m_dsel) - 1; end
                2: if (!m_en) nst = 0;
                   else if (k) nst = 1;
                   else if (m_dly == 0) nst = 3;
                   else m_dly = m_dly - 1;
                default: nst = m_en ? 1 : 0;
            endcase
            m_cnt = (k || !runs || tk) ? 0 : m_cnt + 1;
            if (tk) m_flag = 1; else if (fc) m_flag = 0;
            if (wr_en && !reg_sel && m_unl) begin
                m_en = wdata[2]; m_ren = wdata[3]; m_ien = wdata[4];
                m_psel = (int'(wdata[8:5]) > 8) ? 8 : int'(wdata[8:5]);
                m_dsel = int'(wdata[10:9]);
            end
            if (wr_en && reg_sel) m_unl = wdata[0];
            m_st = nst;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [10:0] exp_rd();
        logic [10:0] r;
        r = '0;
        if (reg_sel) r[0] = m_unl;
        else begin
            r[1] = m_flag; r[2] = m_en; r[3] = m_ren; r[4] = m_ien;
            r[8:5] = 4'(m_psel); r[10:9] = 2'(m_dsel);
        end
        return r;
    endfunction

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(tmo_flag === m_flag, "R3 flag", int'(tmo_flag), int'(m_flag));
            chk(irq === (m_flag && m_ien), "R4 irq", int'(irq), int'(m_flag && m_ien));
            chk(rst_req === (m_st == 3), "R6 rst_req", int'(rst_req), int'(m_st == 3));
            chk(rdata === exp_rd(), "R9 rdata", int'(rdata), int'(exp_rd()));
        end
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wr(input bit sel, input logic [10:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; reg_sel = sel; wdata = d;
        @(negedge clk); #1;
        wr_en = 1'b0; reg_sel = 1'b0; wdata = '0;
    endtask

    function automatic logic [10:0] cw(bit en, bit ren, bit ien, int p, int d, bit k, bit fc);
        logic [10:0] w;
        w = '0;
        w[0] = k; w[1] = fc; w[2] = en; w[3] = ren; w[4] = ien;
        w[8:5] = 4'(p); w[10:9] = 2'(d);
        return w;
    endfunction

    // edges from the current point until tmo_flag is seen
    task automatic edges_to_flag(output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!tmo_flag && n < 5000);
    endtask

    task automatic edges_to_pulse(output int n);
        n = 0;
        do begin
            @(posedge clk); n++;
            @(negedge clk);
        end while (!rst_req && n < 5000);
    endtask

    // issues a write, then measures the flag (edges after the write edge)
    task automatic run_case(input int p, input int d, input int exp_per, input int exp_dly,
                            input string tp, input string td);
        int n;
        @(negedge clk); #1;
        wr_en = 1'b1; reg_sel = 1'b0; wdata = cw(1, 1, 1, p, d, 1, 1);
        @(posedge clk); #1;
        wr_en = 1'b0; wdata = '0;
        edges_to_flag(n);
        chk(n == exp_per, tp, n, exp_per);
        edges_to_pulse(n);
        chk(n == exp_dly, td, n, exp_dly);
    endtask

    initial begin
        int n;
        bit seen;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        chk(rdata == 11'h71C, "R8 reset cfg", int'(rdata), 'h71C);
        chk(!tmo_flag && !rst_req, "R8 reset outputs", int'(tmo_flag | rst_req), 0);

        // R9 locked write ignored
        wr(0, cw(1, 1, 1, 0, 0, 0, 0));
        @(negedge clk);
        chk(rdata[8:5] == 4'd8, "R9 locked psel", int'(rdata[8:5]), 8);

        wr(1, 11'd1);
        // R1 / R5 period 16, delay 3
        run_case(0, 0, 16, 3, "R1 period sel0", "R5 delay sel0");
        chk(irq == 1'b1, "R4 irq on flag", int'(irq), 1);
        run_case(1, 1, 64, 18, "R2 period sel1", "R5 delay sel1");
        run_case(0, 2, 16, 130, "R1 period repeat", "R5 delay sel2");
        run_case(0, 3, 16, 1026, "R1 period again", "R5 delay sel3");
        @(posedge clk); @(negedge clk);
        chk(rst_req == 1'b0, "R6 single pulse", int'(rst_req), 0);

        // R7 kick during grace cancels the reset
        @(negedge clk); #1;
        wr_en = 1'b1; wdata = cw(1, 1, 1, 2, 3, 1, 1);
        @(posedge clk); #1; wr_en = 1'b0; wdata = '0;
        edges_to_flag(n);
        chk(n == 256, "R1 period sel2", n, 256);
        repeat (500) @(posedge clk);
        wr(0, cw(1, 1, 1, 2, 3, 1, 0));
        seen = 0;
        repeat (1100) begin @(negedge clk); if (rst_req) seen = 1; end
        chk(!seen, "R7 kick cancels reset", int'(seen), 0);
        chk(tmo_flag == 1'b1, "R7 flag kept after kick", int'(tmo_flag), 1);

        // R11 reset disabled: flag only
        @(negedge clk); #1;
        wr_en = 1'b1; wdata = cw(1, 0, 1, 0, 0, 1, 1);
        @(posedge clk); #1; wr_en = 1'b0; wdata = '0;
        edges_to_flag(n);
        chk(n == 16, "R11 period", n, 16);
        seen = 0;
        repeat (40) begin @(negedge clk); if (rst_req) seen = 1; end
        chk(!seen, "R11 no reset request", int'(seen), 0);

        // R4 interrupt masked
        wr(0, cw(1, 0, 0, 2, 0, 1, 0));
        @(negedge clk);
        chk(tmo_flag && !irq, "R4 irq masked", int'(irq), 0);

        // R3 sticky then cleared by write-1
        wr(0, cw(1, 0, 1, 2, 0, 0, 0));
        @(negedge clk);
        chk(tmo_flag == 1'b1, "R3 flag sticky", int'(tmo_flag), 1);
        wr(0, cw(1, 0, 1, 2, 0, 1, 1));
        chk(tmo_flag == 1'b0, "R3 flag cleared", int'(tmo_flag), 0);

        // R2 clamp of period select
        wr(0, cw(1, 0, 1, 12, 0, 1, 0));
        @(negedge clk);
        chk(rdata[8:5] == 4'd8, "R2 psel clamp", int'(rdata[8:5]), 8);

        // R10 disabled: nothing happens
        wr(0, cw(0, 1, 1, 0, 0, 1, 1));
        seen = 0;
        repeat (100) begin @(negedge clk); if (rst_req || tmo_flag) seen = 1; end
        chk(!seen, "R10 disabled quiet", int'(seen), 0);

        // R9 relock and attempt enable
        wr(1, 11'd0);
        wr(0, cw(1, 1, 1, 0, 0, 0, 0));
        @(negedge clk);
        chk(rdata[2] == 1'b0, "R9 relocked enable", int'(rdata[2]), 0);

        repeat (5) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule